// File: doc/BRIEF.md
# Regulator-Gated Transmit Start Controller

This controller sits between the wake-up logic of a battery-powered, button-driven encoder and its radio transmitter. It decides the cycle in which a transmission may begin. A button press wakes the controller from sleep. From there it follows one of two start policies, chosen by a configuration bit that is sampled at the wake.

In the gated policy, the controller holds off the transmitter until a power-good input shows that the boosted supply has reached regulation. If power-good does not arrive within a timeout window, the press is abandoned: no transmission starts, a one-cycle failure pulse is raised, and the controller goes back to sleep. In the fixed-delay policy, the transmitter starts after a fixed number of millisecond ticks and power-good is ignored.

Time is counted in pulses of a 1 ms timebase input. The tick counter is cleared while the controller sleeps, so every wake counts from zero. Once a transmission has started, the controller stays busy until the transmitter reports that it is done.

A second configuration bit turns the controller's sleep-indicator pin into an output. When it is enabled, the pin is high while the controller sleeps and low while it is awake. It can be used to cut a leakage path through the regulator's feedback divider. When it is disabled, the pin is left as an input for the spare button it shares, and its driver is switched off.

All pins are plain control and status levels or single-cycle pulses. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `txg_ctrl`

## Requirements
- R1: After reset the controller is asleep. tx_start_o and fail_o are 0. sleep_o is 1 when cfg_sleep_pin_en_i is 1.
- R2: In the gated policy (cfg_wait_en_i=1 at the wake), tx_start_o never asserts unless pwr_good_i was 1 in the previous cycle.
- R3: In the gated policy, if pwr_good_i is 1 in a cycle before the timeout, tx_start_o is 1 in the next cycle.
- R4: In the gated policy, if pwr_good_i stays 0, the cycle after the TIMEOUT_MS-th tick (default 250) shows fail_o=1 and tx_start_o=0. fail_o lasts one cycle, and the controller is asleep one cycle later. A later power-good on its own starts nothing.
- R5: In the fixed-delay policy (cfg_wait_en_i=0 at the wake), tx_start_o is 1 exactly in the cycle after the DELAY_MS-th tick (default 30), whatever the value of pwr_good_i.
- R6: tx_start_o is a single-cycle pulse. The controller stays busy until tx_done_i is 1, then goes back to sleep.
- R7: A wake_i pulse while the controller is awake has no effect. In particular, it does not restart the tick count.
- R8: With cfg_sleep_pin_en_i=1, sleep_oe_o=1, and sleep_o is 0 from the cycle after a wake until the controller is asleep again.
- R9: With cfg_sleep_pin_en_i=0, sleep_oe_o=0 and sleep_o=0 at all times.
- R10: fail_o and tx_start_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake_i | input | 1 | Button-press wake pulse |
| pwr_good_i | input | 1 | Boosted supply is in regulation |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond |
| cfg_wait_en_i | input | 1 | 1 = gated policy, 0 = fixed-delay policy |
| cfg_sleep_pin_en_i | input | 1 | Enable the sleep-indicator output driver |
| tx_done_i | input | 1 | Transmitter has finished |
| tx_start_o | output | 1 | One-cycle transmit start pulse |
| fail_o | output | 1 | One-cycle regulation-timeout pulse |
| sleep_o | output | 1 | Sleep-indicator pin value |
| sleep_oe_o | output | 1 | Output enable for the sleep-indicator pin |

## Verification
The hardest case to reach is the timeout boundary of the gated policy. Getting there takes a full window of ticks with power-good held low. The outcome must then be checked on the exact tick where the attempt turns into a failure rather than a late start.

The stimulus drives ticks one at a time from a task. It checks for silence after every tick up to the one before the limit, then checks the failure pulse after the limit tick. It then raises power-good once the controller is asleep again, to show that the abandoned press cannot still start a transmission. A stray wake is injected halfway through a fixed-delay count to show that the count is not restarted.

// File: rtl/txg_pkg.sv
package txg_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP = 3'd0,
    ST_WAIT  = 3'd1,
    ST_DELAY = 3'd2,
    ST_TX    = 3'd3,
    ST_FAIL  = 3'd4
  } txg_state_e;
endpackage

// File: rtl/txg_tick_cnt.sv
module txg_tick_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end

  // R4 / R5: the controller always leaves the counting states before the count can wrap
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i) |-> (cnt_o != CNT_MAX));
endmodule

// File: rtl/txg_fsm.sv
module txg_fsm
  import txg_pkg::*;
#(
  parameter int TIMEOUT_MS = 250,
  parameter int DELAY_MS   = 30,
  parameter int W          = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wake_i,
  input  logic         pwr_good_i,
  input  logic         tick_i,
  input  logic         cfg_wait_i,
  input  logic         tx_done_i,
  input  logic [W-1:0] cnt_i,
  output logic         cnt_clr_o,
  output logic         cnt_inc_o,
  output logic         tx_start_o,
  output logic         fail_o,
  output logic         asleep_o
);
  localparam logic [W-1:0] TO_LAST = W'(TIMEOUT_MS - 1);
  localparam logic [W-1:0] DL_LAST = W'(DELAY_MS - 1);

  txg_state_e st, nxt;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_SLEEP: if (wake_i) nxt = cfg_wait_i ? ST_WAIT : ST_DELAY;
      ST_WAIT: begin
        if (pwr_good_i)                      nxt = ST_TX;
        else if (tick_i && cnt_i == TO_LAST) nxt = ST_FAIL;
      end
      ST_DELAY: if (tick_i && cnt_i == DL_LAST) nxt = ST_TX;
      ST_TX:    if (tx_done_i) nxt = ST_SLEEP;
      ST_FAIL:  nxt = ST_SLEEP;
      default:  nxt = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_SLEEP;
      tx_start_o <= 1'b0;
      fail_o     <= 1'b0;
    end else begin
      st         <= nxt;
      tx_start_o <= (nxt == ST_TX)   && (st != ST_TX);
      fail_o     <= (nxt == ST_FAIL) && (st != ST_FAIL);
    end
  end

  assign cnt_clr_o = (st == ST_SLEEP);
  assign cnt_inc_o = tick_i && ((st == ST_WAIT) || (st == ST_DELAY));
  assign asleep_o  = (st == ST_SLEEP);

  // R2: a gated start always follows a cycle with power good
  p_gated_needs_pg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start_o && $past(st) == ST_WAIT) |-> $past(pwr_good_i));
  // R3: power good during the wait starts the transmitter next cycle
  p_pg_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && pwr_good_i) |=> tx_start_o);
  // R4: a failure only follows the last tick of the window
  p_fail_at_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> ($past(cnt_i) == TO_LAST && $past(tick_i) && !$past(pwr_good_i)));
  // R5: a fixed-delay start only follows the last delay tick
  p_delay_exact_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start_o && $past(st) == ST_DELAY) |-> ($past(cnt_i) == DL_LAST && $past(tick_i)));
  // R6: single-cycle start, busy until done
  p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_o |=> !tx_start_o);
  p_hold_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TX && !tx_done_i) |=> (st == ST_TX));
  // R7: wake while awake does not clear the count
  p_wake_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DELAY && wake_i && !tick_i && nxt == ST_DELAY) |=> $stable(cnt_i));
  // R10: failure and start are exclusive
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fail_o && tx_start_o));
  p_fail_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |=> !fail_o);
endmodule

// File: rtl/txg_ctrl.sv
module txg_ctrl #(
  parameter int TIMEOUT_MS = 250,
  parameter int DELAY_MS   = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_i,
  input  logic pwr_good_i,
  input  logic tick_ms_i,
  input  logic cfg_wait_en_i,
  input  logic cfg_sleep_pin_en_i,
  input  logic tx_done_i,
  output logic tx_start_o,
  output logic fail_o,
  output logic sleep_o,
  output logic sleep_oe_o
);
  localparam int LIMIT = (TIMEOUT_MS > DELAY_MS) ? TIMEOUT_MS : DELAY_MS;
  localparam int W     = $clog2(LIMIT + 1);

  logic [W-1:0] cnt;
  logic         cnt_clr, cnt_inc, asleep;

  txg_tick_cnt #(.W(W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .cnt_o (cnt)
  );

  txg_fsm #(.TIMEOUT_MS(TIMEOUT_MS), .DELAY_MS(DELAY_MS), .W(W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .wake_i     (wake_i),
    .pwr_good_i (pwr_good_i),
    .tick_i     (tick_ms_i),
    .cfg_wait_i (cfg_wait_en_i),
    .tx_done_i  (tx_done_i),
    .cnt_i      (cnt),
    .cnt_clr_o  (cnt_clr),
    .cnt_inc_o  (cnt_inc),
    .tx_start_o (tx_start_o),
    .fail_o     (fail_o),
    .asleep_o   (asleep)
  );

  assign sleep_oe_o = cfg_sleep_pin_en_i;
  assign sleep_o    = cfg_sleep_pin_en_i & asleep;

  // R8: with the pin enabled, a wake from sleep drops the indicator next cycle
  p_wake_drops_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sleep_pin_en_i && sleep_o && wake_i) ##1 cfg_sleep_pin_en_i |-> !sleep_o);
  // R9: pin driver off when the option is off
  p_pin_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_sleep_pin_en_i |-> (!sleep_oe_o && !sleep_o));
endmodule

// File: tb/tb_txg_ctrl.sv
`timescale 1ns/1ps
module tb_txg_ctrl;
  localparam int TO = 250;
  localparam int DL = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wake = 0, pg = 0, tick = 0, cfg_wait = 0, cfg_pin = 1, done = 0;
  logic tx_start, fail, slp, slp_oe;
  int   n_chk = 0, n_bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  txg_ctrl #(.TIMEOUT_MS(TO), .DELAY_MS(DL)) dut (
    .clk(clk), .rst_n(rst_n), .wake_i(wake), .pwr_good_i(pg), .tick_ms_i(tick),
    .cfg_wait_en_i(cfg_wait), .cfg_sleep_pin_en_i(cfg_pin), .tx_done_i(done),
    .tx_start_o(tx_start), .fail_o(fail), .sleep_o(slp), .sleep_oe_o(slp_oe));

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1; step(); tick = 0;
  endtask

  task automatic do_wake();
    wake = 1; step(); wake = 0;
  endtask

  task automatic finish_tx();
    done = 1; step(); done = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic t_reset();
    step();
    chk("R1 tx_start", tx_start, 0);
    chk("R1 fail", fail, 0);
    chk("R1 sleep_o", slp, 1);
    rst_n = 1; step();
    chk("R1 sleep_o after release", slp, 1);
  endtask

  task automatic t_gated_ok();
    cfg_wait = 1; pg = 0;
    do_wake();
    chk("R8 sleep_o low after wake", slp, 0);
    chk("R8 sleep_oe", slp_oe, 1);
    for (int i = 0; i < 10; i++) begin
      pulse_tick();
      chk("R2 held off without pg", tx_start, 0);
    end
    pg = 1; step(); pg = 0;
    chk("R3 start after pg", tx_start, 1);
    chk("R10 no fail with start", fail, 0);
    step();
    chk("R6 single pulse", tx_start, 0);
    for (int i = 0; i < 5; i++) step();
    chk("R6 busy before done", slp, 0);
    finish_tx();
    chk("R6 asleep after done", slp, 1);
  endtask

  task automatic t_gated_timeout();
    cfg_wait = 1; pg = 0;
    do_wake();
    for (int i = 0; i < TO - 1; i++) begin
      pulse_tick();
      if (fail || tx_start) chk("R4 nothing before limit", 1'b1, 1'b0);
    end
    chk("R4 no fail before limit", fail, 0);
    pulse_tick();
    chk("R4 fail at limit", fail, 1);
    chk("R4 no start on timeout", tx_start, 0);
    step();
    chk("R4 fail single cycle", fail, 0);
    chk("R4 asleep after fail", slp, 1);
    pg = 1; step(); step(); pg = 0;
    chk("R4 late pg starts nothing", tx_start, 0);
  endtask

  task automatic t_delay(input logic pg_level);
    cfg_wait = 0; pg = pg_level;
    do_wake();
    for (int i = 0; i < DL - 1; i++) begin
      pulse_tick();
      if (tx_start) chk("R5 no early start", tx_start, 0);
    end
    chk("R5 no start at tick 29", tx_start, 0);
    pulse_tick();
    chk("R5 start at delay tick", tx_start, 1);
    pg = 0;
    step();
    finish_tx();
    chk("R6 asleep after delay tx", slp, 1);
  endtask

  task automatic t_wake_ignored();
    cfg_wait = 0; pg = 0;
    do_wake();
    for (int i = 0; i < 15; i++) pulse_tick();
    do_wake();
    for (int i = 0; i < 14; i++) pulse_tick();
    chk("R7 no restart: no start yet", tx_start, 0);
    pulse_tick();
    chk("R7 start at original 30th tick", tx_start, 1);
    step();
    do_wake();
    chk("R7 wake during tx no effect", slp, 0);
    finish_tx();
    chk("R7 asleep after done", slp, 1);
  endtask

  task automatic t_pin_off();
    cfg_pin = 0; step();
    chk("R9 oe off", slp_oe, 0);
    chk("R9 pin low asleep", slp, 0);
    cfg_wait = 1; pg = 0;
    do_wake();
    chk("R9 pin low awake", slp, 0);
    pg = 1; step(); pg = 0;
    step(); finish_tx();
    chk("R9 oe off after tx", slp_oe, 0);
    cfg_pin = 1; step();
    chk("R8 pin high asleep when enabled", slp, 1);
  endtask

  initial begin
    t_reset();
    t_gated_ok();
    t_gated_timeout();
    t_delay(1'b0);
    t_delay(1'b1);
    t_wake_ignored();
    t_pin_off();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule